// File: doc/BRIEF.md
# Pipelined Adder Reduction Accumulator

The block adds up a stream of values that can arrive once per clock cycle. It uses a single adder whose result appears a fixed number of cycles after its operands enter. A plain feedback loop around that adder would read a sum that is not ready yet. The block avoids this by keeping one independent partial sum in each adder stage while the stream runs.

While the enable is high, each incoming word is added to the word leaving the adder. This keeps as many partial sums in flight as the adder has stages. When the enable falls, the block starts merging. Each word leaving the adder is held in a one-entry buffer until a second word arrives. The two words then go back into the adder together. The block repeats this until only the buffered word is left, then presents it as the total together with a one-cycle done pulse.

In this version the adder is an integer adder. Its depth is a parameter, 14 by default. The total is taken modulo 2^DATA_W.

Top module: `acc_reduce`

## Requirements
- R1: After reset is released, sum_o is 0, done_o is 0 and overrun_o is 0.
- R2: For a stream of consecutive enabled cycles, the total of all data_i values modulo 2^DATA_W is shown on sum_o in the cycle in which done_o is 1.
- R3: done_o is high for exactly one cycle per stream. sum_o changes only together with done_o and keeps its value until the next done_o.
- R4: A data_i word is accepted on every enabled cycle with no stall. Streams much longer than the adder depth give the correct total.
- R5: Streams shorter than the adder depth, including a single word, give the correct total.
- R6: Stage occupancy is tracked with valid bits rather than by value. A stream whose partial sums are all zero still completes, with total 0.
- R7: done_o rises no later than 8*LAT clock cycles after the first cycle in which en_i is low.
- R8: If en_i is high while the block is still merging, the word is ignored and does not enter the total. overrun_o becomes 1 and stays 1 until the next stream is accepted after done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | High for each cycle that carries a stream word; falling edge ends the stream |
| data_i | input | DATA_W | Stream word |
| sum_o | output | DATA_W | Total of the last completed stream |
| done_o | output | 1 | One-cycle pulse when sum_o is updated |
| overrun_o | output | 1 | Sticky flag: enable seen while merging |

## Verification
The checks assume that each stream is one unbroken run of enabled cycles, and that the next stream starts only after done_o. Under that assumption, done_o fires exactly once per stream and sum_o moves only with it. The stimulus follows this rule for every stream except the overrun case. That case raises the enable for one cycle in the middle of merging. It then waits for done_o before it starts the following stream, so the sticky flag and the exclusion of the stray word can both be observed.

// File: rtl/acc_pkg.sv
package acc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STREAM = 2'd1,
    ST_MERGE  = 2'd2
  } acc_state_e;
endpackage

// File: rtl/acc_add_pipe.sv
module acc_add_pipe #(
  parameter int W   = 32,
  parameter int LAT = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         res_v_o,
  output logic         busy_o
);
  logic [W-1:0] d_q [LAT];
  logic [LAT-1:0] v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LAT; i++) d_q[i] <= '0;
      v_q <= '0;
    end else begin
      d_q[0] <= a_i + b_i;
      v_q[0] <= push_i;
      for (int i = 1; i < LAT; i++) begin
        d_q[i] <= d_q[i-1];
        v_q[i] <= v_q[i-1];
      end
    end
  end

  assign res_o   = d_q[LAT-1];
  assign res_v_o = v_q[LAT-1];
  assign busy_o  = |v_q;
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] res_i,
  input  logic         res_v_i,
  input  logic         busy_i,
  output logic         push_o,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic [W-1:0] sum_o,
  output logic         done_o,
  output logic         overrun_o,
  output acc_state_e   st_o,
  output logic         hold_v_o
);
  acc_state_e   st_q;
  logic [W-1:0] hold_q;
  logic         hold_v_q;
  logic         accept, merge, finish;

  assign accept = en_i && (st_q != ST_MERGE);
  assign merge  = (st_q == ST_MERGE) || (st_q == ST_STREAM && !en_i);
  assign finish = (st_q == ST_MERGE) && hold_v_q && !busy_i;

  // operand muxes: stream feedback or buffer pairing
  always_comb begin
    push_o = 1'b0;
    a_o    = '0;
    b_o    = '0;
    if (accept) begin
      push_o = 1'b1;
      a_o    = data_i;
      b_o    = res_v_i ? res_i : '0;
    end else if (merge && res_v_i && hold_v_q) begin
      push_o = 1'b1;
      a_o    = hold_q;
      b_o    = res_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      hold_q    <= '0;
      hold_v_q  <= 1'b0;
      sum_o     <= '0;
      done_o    <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (en_i) begin
          st_q      <= ST_STREAM;
          overrun_o <= 1'b0;
        end
        ST_STREAM: if (!en_i) st_q <= ST_MERGE;
        ST_MERGE: begin
          if (en_i) overrun_o <= 1'b1;
          if (finish) begin
            st_q   <= ST_IDLE;
            sum_o  <= hold_q;
            done_o <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
      if (merge && res_v_i) begin
        if (hold_v_q) hold_v_q <= 1'b0;
        else begin
          hold_q   <= res_i;
          hold_v_q <= 1'b1;
        end
      end else if (finish) begin
        hold_v_q <= 1'b0;
      end
    end
  end

  assign st_o     = st_q;
  assign hold_v_o = hold_v_q;
endmodule

// File: rtl/acc_reduce.sv
module acc_reduce
  import acc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LAT    = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              done_o,
  output logic              overrun_o
);
  logic [DATA_W-1:0] op_a, op_b, res;
  logic              push, res_v, busy, hold_v;
  acc_state_e        st;

  acc_add_pipe #(.W(DATA_W), .LAT(LAT)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .a_i    (op_a),
    .b_i    (op_b),
    .res_o  (res),
    .res_v_o(res_v),
    .busy_o (busy)
  );

  acc_ctrl #(.W(DATA_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .data_i   (data_i),
    .res_i    (res),
    .res_v_i  (res_v),
    .busy_i   (busy),
    .push_o   (push),
    .a_o      (op_a),
    .b_o      (op_b),
    .sum_o    (sum_o),
    .done_o   (done_o),
    .overrun_o(overrun_o),
    .st_o     (st),
    .hold_v_o (hold_v)
  );
endmodule

// File: rtl/acc_reduce_chk.sv
module acc_reduce_chk
  import acc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [DATA_W-1:0] sum_o,
  input logic              done_o,
  input logic              overrun_o,
  input acc_state_e        st,
  input logic              push,
  input logic              res_v,
  input logic              hold_v,
  input logic              busy
);
  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R3
  sum_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(sum_o));
  // R8
  overrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_MERGE && en_i) |=> overrun_o);
  // R4
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st != ST_MERGE && en_i) |-> push);
  // R2
  pair_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_MERGE && hold_v && res_v) |=> !hold_v);
  // R6
  done_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy);
endmodule

bind acc_reduce acc_reduce_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .sum_o    (sum_o),
  .done_o   (done_o),
  .overrun_o(overrun_o),
  .st       (st),
  .push     (push),
  .res_v    (res_v),
  .hold_v   (hold_v),
  .busy     (busy)
);

// File: tb/acc_reduce_bench.sv
module acc_reduce_bench;
  localparam int DATA_W = 32;
  localparam int LAT    = 14;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              en_i = 1'b0;
  logic [DATA_W-1:0] data_i = '0;
  logic [DATA_W-1:0] sum_o;
  logic              done_o, overrun_o;

  int checks = 0;
  int fails  = 0;
  logic [DATA_W-1:0] exp_sum;

  always #2 clk = ~clk;

  acc_reduce #(.DATA_W(DATA_W), .LAT(LAT)) u_acc_reduce (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .data_i(data_i),
    .sum_o(sum_o), .done_o(done_o), .overrun_o(overrun_o)
  );

  task automatic check(input bit ok, input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] gen(input int kind, input int i);
    case (kind)
      0:       gen = $urandom;
      1:       gen = '0;
      2:       gen = '1;
      default: gen = DATA_W'(i + 1);
    endcase
  endfunction

  task automatic drive_stream(input int n, input int kind);
    exp_sum = '0;
    for (int i = 0; i < n; i++) begin
      logic [DATA_W-1:0] v;
      v = gen(kind, i);
      en_i = 1'b1;
      data_i = v;
      exp_sum += v;
      @(negedge clk);
    end
    en_i = 1'b0;
    data_i = '0;
  endtask

  task automatic finish_stream(input string req);
    int  cyc;
    bit  seen;
    cyc = 0;
    seen = 1'b0;
    while (!seen && cyc < 8*LAT + 4) begin
      @(negedge clk);
      cyc++;
      if (done_o) seen = 1'b1;
    end
    check(seen && cyc <= 8*LAT, {"R7 ", req}, DATA_W'(cyc), DATA_W'(8*LAT));
    check(sum_o == exp_sum, {"R2 ", req}, sum_o, exp_sum);
    @(negedge clk);
    check(!done_o, {"R3 pulse ", req}, DATA_W'(done_o), '0);
    repeat (4) @(negedge clk);
    check(sum_o == exp_sum, {"R3 hold ", req}, sum_o, exp_sum);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1
    check(sum_o == '0 && !done_o && !overrun_o, "R1 reset", {sum_o[DATA_W-3:0], done_o, overrun_o}, '0);

    // R5 short streams
    drive_stream(1, 3);  finish_stream("R5 single");
    drive_stream(3, 0);  finish_stream("R5 three");
    drive_stream(LAT-1, 0); finish_stream("R5 lat-1");
    // R4 depth and longer
    drive_stream(LAT, 3);   finish_stream("R4 lat");
    drive_stream(LAT+1, 0); finish_stream("R4 lat+1");
    drive_stream(100, 0);   finish_stream("R4 long");
    drive_stream(257, 3);   finish_stream("R4 ramp");
    // R6 zero stream
    drive_stream(20, 1);    finish_stream("R6 zeros");
    // R2 wraparound
    drive_stream(37, 2);    finish_stream("R2 wrap");
    for (int k = 0; k < 6; k++) begin
      drive_stream(1 + int'($urandom_range(0, 60)), 0);
      finish_stream("R2 random");
    end

    // R8 enable during merge
    drive_stream(30, 0);
    repeat (3) @(negedge clk);
    en_i = 1'b1;
    data_i = 32'd1000;
    @(negedge clk);
    en_i = 1'b0;
    data_i = '0;
    check(overrun_o, "R8 set", DATA_W'(overrun_o), 1);
    finish_stream("R8 ignored");
    check(overrun_o, "R8 sticky", DATA_W'(overrun_o), 1);
    en_i = 1'b1;
    data_i = 32'd7;
    exp_sum = 32'd7;
    @(negedge clk);
    check(!overrun_o, "R8 clear", DATA_W'(overrun_o), 0);
    en_i = 1'b0;
    data_i = '0;
    finish_stream("R8 after");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule